// File: doc/BRIEF.md
# Data-Side Translation Lookup with Fault Recording

This block turns a data virtual address into a physical address through a fully associative buffer of translation entries. Each lookup names an access type: user or kernel with the primary context, user or kernel with the secondary context, or nucleus. The access type selects the 13-bit context that is matched against the stored entries. A lookup also carries a write flag and the processor's privileged-state flag. It returns one of three results: a hit with a physical address, a privilege fault, or a miss.

Faults and misses leave a trace in three registers that software reads directly. The fault status word records how the faulting access was made and flags an earlier fault that was never cleared. The fault address register keeps the full faulting address. The tag access register keeps the page and context of the most recent miss, so a refill handler knows what to load. Entries are loaded through a plain write port; page-table walking is not part of the block.

Requests flow on a valid/ready pair and results on a second one. A request is accepted only when the result register is empty or is being emptied in the same cycle. An unaccepted result stays fixed until the consumer takes it. Context registers, the entry write port and the status write port are plain control pins.

Top module: `dxlat_unit`

## Requirements
- R1: A lookup hits an entry only when that entry is valid, its stored context equals the selected context, and its stored page tag equals address bits 63:13. With no such entry the result is a miss.
- R2: Access type codes 0 (user) and 1 (kernel) select the primary context input. Codes 2 (user) and 3 (kernel) select the secondary context input. Code 4 and codes 5 to 7 use context 0. Only codes 0 and 2 count as user accesses.
- R3: When several entries match, the entry with the lowest index supplies the result.
- R4: Result kind codes are 0 hit, 1 fault and 2 miss. On a hit the physical address is the entry's page number above address bits 12:0, and none of the three software-visible registers changes.
- R5: A user access that hits an entry marked privileged gives kind 1 with a zero physical address. A kernel access to the same entry hits.
- R6: On a fault the status word is loaded as follows: bit 0 valid = 1; bit 2 = write flag; bit 3 = privileged-state flag; bits 5:4 = context type (0 primary, 1 secondary, 2 for code 4 and codes 5 to 7); bit 7 privilege-fault type = 1; bit 6 = 0.
- R7: Status bit 1 (overwrite) of the new word is set when status bit 0 was already 1 at the time of the fault, and is clear otherwise.
- R8: On a fault the fault address register is loaded with the whole 64-bit virtual address.
- R9: On a miss the tag access register is loaded with address bits 63:13 above the 13-bit selected context. The status and fault address registers are left unchanged.
- R10: A status write loads the status register with the write data, so writing zero clears the valid bit. A fault recorded in the same cycle takes precedence over the write.
- R11: req_ready equals !rsp_valid || rsp_ready. Each accepted request gives exactly one result, which is valid from the next cycle on. A result that is not taken holds its kind and address.
- R12: An entry write sets the entry's valid bit, context, page tag, privileged bit and page number. Lookups accepted in a later cycle see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_ctx | input | 13 | Primary context value |
| sec_ctx | input | 13 | Secondary context value |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | 6 | Entry index to write |
| ent_valid | input | 1 | Valid bit for the written entry |
| ent_ctx | input | 13 | Context for the written entry |
| ent_vpn | input | 51 | Virtual page tag for the written entry |
| ent_priv | input | 1 | Privileged-only marker for the written entry |
| ent_ppn | input | 28 | Physical page number for the written entry |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_va | input | 64 | Virtual address |
| req_acc | input | 3 | Access type code |
| req_write | input | 1 | Access is a write |
| req_priv_state | input | 1 | Processor is in privileged state |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_kind | output | 2 | 0 hit, 1 fault, 2 miss |
| rsp_pa | output | 41 | Physical address on a hit, zero otherwise |
| st_we | input | 1 | Software write of the status register |
| st_wdata | input | 8 | Status write data |
| fault_status | output | 8 | Fault status word |
| fault_addr | output | 64 | Fault address register |
| tag_access | output | 64 | Tag access register |

## Verification
A corrupted entry or a broken priority choice shows up in the very next result as the wrong kind or the wrong page number, so every lookup is compared against a model of the buffer. Errors in fault recording only show in the software-visible registers. They can surface one cycle after the faulting or missing lookup, or much later as a wrong overwrite bit. For that reason all three registers are compared after every transaction, not only after faults. Stall handling is checked by holding the result and watching both the ready output and the held result across cycles.

// File: rtl/dxlat_pkg.sv
package dxlat_pkg;

  // access type codes
  localparam logic [2:0] ACC_USR_PRI = 3'd0;
  localparam logic [2:0] ACC_KRN_PRI = 3'd1;
  localparam logic [2:0] ACC_USR_SEC = 3'd2;
  localparam logic [2:0] ACC_KRN_SEC = 3'd3;
  localparam logic [2:0] ACC_NUCLEUS = 3'd4;

  // context type codes recorded in the status word
  localparam logic [1:0] CT_PRI = 2'd0;
  localparam logic [1:0] CT_SEC = 2'd1;
  localparam logic [1:0] CT_NUC = 2'd2;

  // result kinds
  localparam logic [1:0] RSP_HIT   = 2'd0;
  localparam logic [1:0] RSP_FAULT = 2'd1;
  localparam logic [1:0] RSP_MISS  = 2'd2;

  // status word layout
  localparam int ST_W     = 8;
  localparam int ST_VLD   = 0;
  localparam int ST_OW    = 1;
  localparam int ST_WR    = 2;
  localparam int ST_PRIV  = 3;
  localparam int ST_CT_LO = 4;
  localparam int ST_FT    = 7;

endpackage

// File: rtl/dxlat_ctx_sel.sv
module dxlat_ctx_sel
  import dxlat_pkg::*;
#(
  parameter int CTX_W = 13
) (
  input  logic [2:0]       acc,
  input  logic [CTX_W-1:0] pri_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  output logic [CTX_W-1:0] ctx,
  output logic [1:0]       ctype,
  output logic             is_user
);

  always_comb begin
    unique case (acc)
      ACC_USR_PRI, ACC_KRN_PRI: begin
        ctx   = pri_ctx;
        ctype = CT_PRI;
      end
      ACC_USR_SEC, ACC_KRN_SEC: begin
        ctx   = sec_ctx;
        ctype = CT_SEC;
      end
      default: begin
        ctx   = '0;
        ctype = CT_NUC;
      end
    endcase
  end

  assign is_user = (acc == ACC_USR_PRI) || (acc == ACC_USR_SEC);

endmodule

// File: rtl/dxlat_array.sv
module dxlat_array #(
  parameter int ENTRIES = 64,
  parameter int CTX_W   = 13,
  parameter int VPN_W   = 51,
  parameter int PPN_W   = 28,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wvalid,
  input  logic [CTX_W-1:0] wctx,
  input  logic [VPN_W-1:0] wvpn,
  input  logic             wpriv,
  input  logic [PPN_W-1:0] wppn,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic             hit_priv,
  output logic [PPN_W-1:0] hit_ppn
);

  logic             vld_q [ENTRIES];
  logic             prv_q [ENTRIES];
  logic [CTX_W-1:0] ctx_q [ENTRIES];
  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_here;
    assign wr_here = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[g] <= 1'b0;
      else if (wr_here) vld_q[g] <= wvalid;
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        ctx_q[g] <= wctx;
        vpn_q[g] <= wvpn;
        prv_q[g] <= wpriv;
        ppn_q[g] <= wppn;
      end
    end

    assign match[g] = vld_q[g] && (ctx_q[g] == lk_ctx) && (vpn_q[g] == lk_vpn);
  end

  // lowest index wins: scan downward so the last assignment is the lowest match
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign hit_priv = prv_q[sel];
  assign hit_ppn  = ppn_q[sel];

  AST_WR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (vld_q[$past(widx)] == $past(wvalid))); // R12

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (match[sel] && ((match & ((ENTRIES'(1) << sel) - ENTRIES'(1))) == '0))); // R3

endmodule

// File: rtl/dxlat_fault_rec.sv
module dxlat_fault_rec
  import dxlat_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PAGE_W = 13,
  parameter int CTX_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             is_fault,
  input  logic             is_miss,
  input  logic             wr,
  input  logic             priv_state,
  input  logic [1:0]       ctype,
  input  logic [CTX_W-1:0] ctx,
  input  logic [VA_W-1:0]  va,
  input  logic             sw_we,
  input  logic [ST_W-1:0]  sw_wdata,
  output logic [ST_W-1:0]  status_q,
  output logic [VA_W-1:0]  far_q,
  output logic [VA_W-1:0]  tag_q
);

  logic [ST_W-1:0] fault_word;
  logic            rec_fault, rec_miss;

  assign rec_fault = fire && is_fault;
  assign rec_miss  = fire && is_miss;

  always_comb begin
    fault_word                   = '0;
    fault_word[ST_VLD]           = 1'b1;
    fault_word[ST_OW]            = status_q[ST_VLD];
    fault_word[ST_WR]            = wr;
    fault_word[ST_PRIV]          = priv_state;
    fault_word[ST_CT_LO +: 2]    = ctype;
    fault_word[ST_FT]            = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      far_q    <= '0;
      tag_q    <= '0;
    end else begin
      if (rec_fault) begin
        status_q <= fault_word;
        far_q    <= va;
      end else if (sw_we) begin
        status_q <= sw_wdata;
      end
      if (rec_miss)
        tag_q <= {va[VA_W-1:PAGE_W], {PAGE_W{1'b0}}} | VA_W'(ctx);
    end
  end

  AST_OW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_fault && status_q[ST_VLD]) |=> status_q[ST_OW]); // R7

  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_miss && !sw_we) |=> ($stable(status_q) && $stable(far_q))); // R9

  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rec_fault |=> (far_q == $past(va) && status_q[ST_VLD] && status_q[ST_FT])); // R8

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !rec_fault && sw_wdata == '0) |=> !status_q[ST_VLD]); // R10

endmodule

// File: rtl/dxlat_unit.sv
module dxlat_unit
  import dxlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int PA_W    = 41,
  parameter int PAGE_W  = 13,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PPN_W  = PA_W - PAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTX_W-1:0] pri_ctx,
  input  logic [CTX_W-1:0] sec_ctx,
  input  logic             ent_we,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic             ent_valid,
  input  logic [CTX_W-1:0] ent_ctx,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic             ent_priv,
  input  logic [PPN_W-1:0] ent_ppn,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [2:0]       req_acc,
  input  logic             req_write,
  input  logic             req_priv_state,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_kind,
  output logic [PA_W-1:0]  rsp_pa,
  input  logic             st_we,
  input  logic [ST_W-1:0]  st_wdata,
  output logic [ST_W-1:0]  fault_status,
  output logic [VA_W-1:0]  fault_addr,
  output logic [VA_W-1:0]  tag_access
);

  logic [CTX_W-1:0] lk_ctx;
  logic [1:0]       lk_ctype;
  logic             lk_user;
  logic             lk_hit, lk_hit_priv;
  logic [PPN_W-1:0] lk_ppn;
  logic             req_fire;
  logic             lk_fault, lk_miss;
  logic [1:0]       kind_d;
  logic [PA_W-1:0]  pa_d;

  dxlat_ctx_sel #(.CTX_W(CTX_W)) u_ctx (
    .acc     (req_acc),
    .pri_ctx (pri_ctx),
    .sec_ctx (sec_ctx),
    .ctx     (lk_ctx),
    .ctype   (lk_ctype),
    .is_user (lk_user)
  );

  dxlat_array #(
    .ENTRIES (ENTRIES),
    .CTX_W   (CTX_W),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ent_we),
    .widx     (ent_idx),
    .wvalid   (ent_valid),
    .wctx     (ent_ctx),
    .wvpn     (ent_vpn),
    .wpriv    (ent_priv),
    .wppn     (ent_ppn),
    .lk_ctx   (lk_ctx),
    .lk_vpn   (req_va[VA_W-1:PAGE_W]),
    .hit      (lk_hit),
    .hit_priv (lk_hit_priv),
    .hit_ppn  (lk_ppn)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign lk_fault  = lk_hit && lk_hit_priv && lk_user;
  assign lk_miss   = !lk_hit;

  always_comb begin
    if (lk_miss) begin
      kind_d = RSP_MISS;
      pa_d   = '0;
    end else if (lk_fault) begin
      kind_d = RSP_FAULT;
      pa_d   = '0;
    end else begin
      kind_d = RSP_HIT;
      pa_d   = {lk_ppn, req_va[PAGE_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= RSP_HIT;
      rsp_pa    <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_kind <= kind_d;
        rsp_pa   <= pa_d;
      end
    end
  end

  dxlat_fault_rec #(
    .VA_W   (VA_W),
    .PAGE_W (PAGE_W),
    .CTX_W  (CTX_W)
  ) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (req_fire),
    .is_fault   (lk_fault),
    .is_miss    (lk_miss),
    .wr         (req_write),
    .priv_state (req_priv_state),
    .ctype      (lk_ctype),
    .ctx        (lk_ctx),
    .va         (req_va),
    .sw_we      (st_we),
    .sw_wdata   (st_wdata),
    .status_q   (fault_status),
    .far_q      (fault_addr),
    .tag_q      (tag_access)
  );

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_kind) && $stable(rsp_pa))); // R11

  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid); // R11

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == RSP_FAULT) |-> (rsp_pa == '0)); // R5

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_kind != 2'd3)); // R4

  AST_HIT_NO_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && lk_hit && !lk_fault && !st_we) |=>
      ($stable(fault_status) && $stable(fault_addr) && $stable(tag_access))); // R4

endmodule

// File: tb/dxlat_unit_tb.sv
`timescale 1ns/1ps
module dxlat_unit_tb;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] pri_ctx = '0, sec_ctx = '0;
  logic        ent_we = 1'b0;
  logic [5:0]  ent_idx = '0;
  logic        ent_valid = 1'b0;
  logic [12:0] ent_ctx = '0;
  logic [50:0] ent_vpn = '0;
  logic        ent_priv = 1'b0;
  logic [27:0] ent_ppn = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [2:0]  req_acc = '0;
  logic        req_write = 1'b0, req_priv_state = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_kind;
  logic [40:0] rsp_pa;
  logic        st_we = 1'b0;
  logic [7:0]  st_wdata = '0;
  logic [7:0]  fault_status;
  logic [63:0] fault_addr, tag_access;

  always #2.5 clk = ~clk;

  dxlat_unit u_dut (.*);

  // bench model
  logic        m_vld [N];
  logic [12:0] m_ctx [N];
  logic [50:0] m_vpn [N];
  logic        m_prv [N];
  logic [27:0] m_ppn [N];
  logic [7:0]  e_stat = '0;
  logic [63:0] e_far = '0, e_tag = '0;

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ent(int idx, bit v, logic [12:0] c, logic [50:0] vpn, bit p, logic [27:0] ppn);
    @(negedge clk);
    ent_we = 1; ent_idx = 6'(idx); ent_valid = v; ent_ctx = c; ent_vpn = vpn; ent_priv = p; ent_ppn = ppn;
    @(posedge clk);
    @(negedge clk);
    ent_we = 0;
    m_vld[idx] = v; m_ctx[idx] = c; m_vpn[idx] = vpn; m_prv[idx] = p; m_ppn[idx] = ppn;
  endtask

  // expected result of one lookup; updates model registers
  function automatic void model(logic [63:0] va, logic [2:0] acc, bit w, bit ps, bit swe, logic [7:0] swd,
                                output logic [1:0] kind, output logic [40:0] pa);
    logic [12:0] c; logic [1:0] ct; bit usr; int hi;
    case (acc)
      3'd0, 3'd1: begin c = pri_ctx; ct = 2'd0; end
      3'd2, 3'd3: begin c = sec_ctx; ct = 2'd1; end
      default:    begin c = '0;      ct = 2'd2; end
    endcase
    usr = (acc == 3'd0) || (acc == 3'd2);
    hi = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_vld[i] && m_ctx[i] == c && m_vpn[i] == va[63:13]) hi = i;
    pa = '0;
    if (hi < 0) begin
      kind = 2'd2;
      e_tag = {va[63:13], c};
      if (swe) e_stat = swd;
    end else if (m_prv[hi] && usr) begin
      kind = 2'd1;
      e_stat = {1'b1, 1'b0, ct, ps, w, e_stat[0], 1'b1};
      e_far = va;
    end else begin
      kind = 2'd0;
      pa = {m_ppn[hi], va[12:0]};
      if (swe) e_stat = swd;
    end
  endfunction

  task automatic lookup(string req, logic [63:0] va, logic [2:0] acc, bit w, bit ps,
                        bit swe = 0, logic [7:0] swd = '0);
    logic [1:0] k; logic [40:0] pa;
    @(negedge clk);
    req_valid = 1; req_va = va; req_acc = acc; req_write = w; req_priv_state = ps;
    st_we = swe; st_wdata = swd;
    model(va, acc, w, ps, swe, swd, k, pa);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; st_we = 0;
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " kind"}, 64'(rsp_kind), 64'(k));
    chk({req, " pa"}, 64'(rsp_pa), 64'(pa));
    chk({req, " status"}, 64'(fault_status), 64'(e_stat));
    chk({req, " far"}, fault_addr, e_far);
    chk({req, " tag"}, tag_access, e_tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [63:0] va;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_ctx[i] = '0; m_vpn[i] = '0; m_prv[i] = 0; m_ppn[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R11, R6)
    chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 reset req_ready", 64'(req_ready), 64'd1);
    chk("R6 reset status", 64'(fault_status), 64'd0);
    chk("R9 reset tag", tag_access, 64'd0);

    // R9 miss on empty buffer
    pri_ctx = 13'h0a5; sec_ctx = 13'h1f0;
    lookup("R9 empty miss", 64'hdead_beef_0000_1234, 3'd0, 0, 0);
    chk("R9 tag value", tag_access, 64'hdead_beef_0000_0000 | 64'h0a5);

    // R3 duplicate match, lowest index wins
    wr_ent(9, 1, 13'h0a5, 51'h7, 0, 28'h999);
    wr_ent(5, 1, 13'h0a5, 51'h7, 0, 28'h555);
    lookup("R3 lowest index", {51'h7, 13'h0abc}, 3'd1, 0, 1);
    chk("R3 pa from entry 5", 64'(rsp_pa), 64'({28'h555, 13'h0abc}));
    // R12 invalidate entry 5, entry 9 takes over
    wr_ent(5, 0, 13'h0a5, 51'h7, 0, 28'h555);
    lookup("R12 after invalidate", {51'h7, 13'h0001}, 3'd1, 0, 1);
    // R1 context mismatch misses
    lookup("R1 ctx mismatch", {51'h7, 13'h0001}, 3'd2, 0, 0);

    // R5 privileged entry, user vs kernel; R6/R7 status bits
    wr_ent(0, 1, 13'h1f0, 51'h4_0000_0000_0003, 1, 28'h0123);
    lookup("R5 kernel priv hit", {51'h4_0000_0000_0003, 13'h10}, 3'd3, 0, 1);
    lookup("R5 user priv fault", {51'h4_0000_0000_0003, 13'h20}, 3'd2, 1, 0);
    chk("R6 status word", 64'(fault_status), 64'h95);
    lookup("R7 overwrite", {51'h4_0000_0000_0003, 13'h30}, 3'd2, 0, 1);
    chk("R7 ow bit", 64'(fault_status[1]), 64'd1);

    // R10 software clear, then fault wins over same-cycle write
    @(negedge clk); st_we = 1; st_wdata = 8'h00;
    @(posedge clk); @(negedge clk); st_we = 0; e_stat = 8'h00;
    chk("R10 clear", 64'(fault_status), 64'd0);
    lookup("R10 fault beats write", {51'h4_0000_0000_0003, 13'h40}, 3'd2, 0, 0, 1'b1, 8'h0f);
    chk("R10 no ow after clear", 64'(fault_status[1]), 64'd0);

    // R2 nucleus and out-of-range codes use context 0
    wr_ent(1, 1, 13'h000, 51'h22, 1, 28'h0777);
    lookup("R2 nucleus user? no: kernel", {51'h22, 13'h5}, 3'd4, 0, 1);
    lookup("R2 code 6 ctx 0", {51'h22, 13'h6}, 3'd6, 0, 1);

    // R11 stall
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_va = {51'h22, 13'h7}; req_acc = 3'd4; req_write = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R11 stalled valid", 64'(rsp_valid), 64'd1);
    chk("R11 stalled ready", 64'(req_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R11 held kind", 64'(rsp_kind), 64'd0);
    chk("R11 held pa", 64'(rsp_pa), 64'({28'h0777, 13'h7}));
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    chk("R11 drained", 64'(rsp_valid), 64'd0);

    // random traffic (R1..R9, R12)
    for (int i = 0; i < N; i++)
      wr_ent(i, ($urandom % 4) != 0, ($urandom % 3 == 0) ? 13'h0 : (($urandom % 2) ? 13'h0a5 : 13'h1f0),
             51'($urandom % 6) | (($urandom % 5 == 0) ? 51'h4_0000_0000_0000 : 51'h0),
             $urandom % 3 == 0, 28'($urandom));
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) begin pri_ctx = ($urandom % 2) ? 13'h0a5 : 13'h1f0; sec_ctx = ($urandom % 2) ? 13'h0a5 : 13'h0; end
      if (n % 97 == 0)
        wr_ent($urandom % N, 1, 13'h0a5, 51'($urandom % 6), $urandom % 2, 28'($urandom));
      va = {51'($urandom % 6) | (($urandom % 5 == 0) ? 51'h4_0000_0000_0000 : 51'h0), 13'($urandom)};
      lookup("R1-random", va, 3'($urandom), $urandom % 2, $urandom % 2,
             ($urandom % 9 == 0), ($urandom % 2) ? 8'h00 : 8'($urandom));
    end

    done = 1;
    summary();
  end

endmodule